// File: doc/BRIEF.md
# Bit-Slip Aware Resynchronization Controller

This block sits behind a locked pseudo-random pattern checker. It decides whether a rise in errors is a real loss of bit alignment or only a burst of line noise. The block receives the checker's per-bit mismatch flag as a stream. It feeds that flag into a second, self-synchronizing checker that uses the same polynomial, x^7 + x^6 + 1.

When the incoming data has slipped by whole bit positions, the mismatch flag is itself a shifted copy of the pattern. A pattern XORed with a shifted copy of itself satisfies the same recurrence, so the second checker sees almost no errors. Under random noise, the second checker disagrees on about half of its bits.

Both error counts are collected over the same window of 1024 accepted bits. At the end of each window the block raises a single-cycle resync request when two conditions hold: the primary count is at or above its threshold, and the slip count is below its own threshold. After a request, the controller ignores one full window before it can request again, which gives the upstream checker time to relock.

The stream input never applies back-pressure. `err_ready` is always high, so every cycle with `err_valid` high transfers one bit. Cycles with `err_valid` low carry no data, and whatever is on `err_flag` during them has no effect.

Top module: `rsc_resync_ctrl`

## Requirements
- R1: `err_ready` is high in every cycle. A beat is accepted only when `err_valid` is high. The value of `err_flag` in a cycle with `err_valid` low changes neither the counts nor the slip checker history.
- R2: A window ends on every 1024th accepted beat. `resync_req` goes high in the cycle after the clock edge that accepts that beat, stays high for exactly one cycle, and is never high at any other time.
- R3: At each window end, `primary_high` is loaded with 1 if the number of accepted beats with `err_flag`=1 in that window is greater than or equal to `thr_primary`, and with 0 otherwise. It holds that value until the next window end.
- R4: The slip checker predicts each accepted bit as the XOR of the accepted bits 7 beats back and 6 beats back. It shifts every accepted bit into its history, whether or not the prediction matched. A slip error is an accepted bit that differs from its prediction.
- R5: At each window end, `slip_low` is loaded with 1 if the window's slip error count is strictly less than `thr_slip`, and with 0 otherwise. It holds that value until the next window end.
- R6: `resync_req` pulses at a window end if and only if that window gives `primary_high`=1 and `slip_low`=1, and no hold-off is active.
- R7: The window end that directly follows a window with a resync pulse never pulses. The window end after that one can pulse again.
- R8: The first 7 accepted beats after reset are excluded from the slip error count. Their history is not yet filled.
- R9: An error stream with no pattern structure (random, about 50% ones) does not cause a resync request, even though its primary rate is high.
- R10: During reset and right after it, `resync_req`, `primary_high` and `slip_low` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Error-flag beat valid |
| err_flag | input | 1 | Per-bit mismatch flag from the locked checker |
| err_ready | output | 1 | Always 1; the block never stalls |
| thr_primary | input | 11 | Primary error count threshold (met when count is greater than or equal to it) |
| thr_slip | input | 11 | Slip error count threshold (met when count is below it) |
| resync_req | output | 1 | One-cycle resynchronization request |
| primary_high | output | 1 | Last window's primary count reached `thr_primary` |
| slip_low | output | 1 | Last window's slip count was below `thr_slip` |

## Verification
All three outputs change one clock edge after the 1024th accepted beat of a window is captured. The bench therefore samples them on the falling edge that follows that capture edge, and it checks again on the next falling edge that the pulse has dropped. Between window ends, any sighting of `resync_req` is counted as a failure. Random idle cycles, carrying junk on `err_flag`, are mixed into every window. If the design counted an idle cycle, its window boundary would move and its flags would disagree with the bench model, which is computed per window from the bit list that the bench drives.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic {
    HOLD_IDLE   = 1'b0,
    HOLD_ACTIVE = 1'b1
  } hold_e;

  function automatic logic rsc_predict(input logic old_a, input logic old_b);
    return old_a ^ old_b;
  endfunction
endpackage

// File: rtl/rsc_slip_checker.sv
module rsc_slip_checker #(
  parameter int LEN   = 7,
  parameter int TAP_A = 7,
  parameter int TAP_B = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat_v,
  input  logic beat_bit,
  output logic slip_err
);
  import rsc_pkg::*;
  localparam int FW = $clog2(LEN + 1);

  logic [LEN-1:0] hist;
  logic [FW-1:0]  fill;
  logic           filled;
  logic           pred;

  assign filled   = (fill == FW'(LEN));
  assign pred     = rsc_predict(hist[TAP_A-1], hist[TAP_B-1]);
  assign slip_err = beat_v && filled && (pred ^ beat_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      fill <= '0;
    end else if (beat_v) begin
      hist <= {hist[LEN-2:0], beat_bit};
      if (!filled) fill <= fill + 1'b1;
    end
  end
endmodule

// File: rtl/rsc_window_meter.sv
module rsc_window_meter #(
  parameter int WIN_LOG2 = 10,
  localparam int CW      = WIN_LOG2 + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat_v,
  input  logic          prim_bit,
  input  logic          slip_bit,
  output logic          last_beat,
  output logic [CW-1:0] prim_total,
  output logic [CW-1:0] slip_total
);
  logic [WIN_LOG2-1:0] idx;
  logic [CW-1:0]       prim_cnt;
  logic [CW-1:0]       slip_cnt;

  assign last_beat  = beat_v && (idx == {WIN_LOG2{1'b1}});
  assign prim_total = prim_cnt + CW'(beat_v && prim_bit);
  assign slip_total = slip_cnt + CW'(slip_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      prim_cnt <= '0;
      slip_cnt <= '0;
    end else if (beat_v) begin
      idx <= idx + 1'b1;
      if (last_beat) begin
        prim_cnt <= '0;
        slip_cnt <= '0;
      end else begin
        prim_cnt <= prim_total;
        slip_cnt <= slip_total;
      end
    end
  end
endmodule

// File: rtl/rsc_decision.sv
module rsc_decision #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          last_beat,
  input  logic [CW-1:0] prim_total,
  input  logic [CW-1:0] slip_total,
  input  logic [CW-1:0] thr_p,
  input  logic [CW-1:0] thr_s,
  output logic          resync,
  output logic          prim_high,
  output logic          slip_low
);
  import rsc_pkg::*;

  hold_e hold;
  logic  hi, lo, fire;

  assign hi   = (prim_total >= thr_p);
  assign lo   = (slip_total < thr_s);
  assign fire = hi && lo && (hold == HOLD_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resync    <= 1'b0;
      prim_high <= 1'b0;
      slip_low  <= 1'b0;
      hold      <= HOLD_IDLE;
    end else if (last_beat) begin
      resync    <= fire;
      prim_high <= hi;
      slip_low  <= lo;
      hold      <= fire ? HOLD_ACTIVE : HOLD_IDLE;
    end else begin
      resync    <= 1'b0;
    end
  end
endmodule

// File: rtl/rsc_resync_ctrl.sv
module rsc_resync_ctrl #(
  parameter int WIN_LOG2 = 10,
  parameter int LEN      = 7,
  parameter int TAP_A    = 7,
  parameter int TAP_B    = 6,
  localparam int CW      = WIN_LOG2 + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          err_valid,
  input  logic          err_flag,
  output logic          err_ready,
  input  logic [CW-1:0] thr_primary,
  input  logic [CW-1:0] thr_slip,
  output logic          resync_req,
  output logic          primary_high,
  output logic          slip_low
);
  logic          slip_err;
  logic          last_beat;
  logic [CW-1:0] prim_total;
  logic [CW-1:0] slip_total;

  assign err_ready = 1'b1;

  rsc_slip_checker #(.LEN(LEN), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_slip (
    .clk(clk), .rst_n(rst_n), .beat_v(err_valid), .beat_bit(err_flag),
    .slip_err(slip_err)
  );

  rsc_window_meter #(.WIN_LOG2(WIN_LOG2)) u_meter (
    .clk(clk), .rst_n(rst_n), .beat_v(err_valid), .prim_bit(err_flag),
    .slip_bit(slip_err), .last_beat(last_beat),
    .prim_total(prim_total), .slip_total(slip_total)
  );

  rsc_decision #(.CW(CW)) u_dec (
    .clk(clk), .rst_n(rst_n), .last_beat(last_beat),
    .prim_total(prim_total), .slip_total(slip_total),
    .thr_p(thr_primary), .thr_s(thr_slip),
    .resync(resync_req), .prim_high(primary_high), .slip_low(slip_low)
  );
endmodule

// File: rtl/rsc_resync_ctrl_chk.sv
module rsc_resync_ctrl_chk #(
  parameter int WIN_LOG2 = 10
) (
  input logic clk,
  input logic rst_n,
  input logic err_valid,
  input logic resync_req,
  input logic primary_high,
  input logic slip_low
);
  localparam int SW = WIN_LOG2 + 2;
  localparam logic [SW-1:0] TWO_WIN = SW'(2) << WIN_LOG2;

  logic [WIN_LOG2-1:0] beat_idx;
  logic                edge_q;
  logic [SW-1:0]       since;
  logic                seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_idx <= '0;
      edge_q   <= 1'b0;
      since    <= '0;
      seen     <= 1'b0;
    end else begin
      if (err_valid) beat_idx <= beat_idx + 1'b1;
      edge_q <= err_valid && (beat_idx == {WIN_LOG2{1'b1}});
      if (resync_req) begin
        seen  <= 1'b1;
        since <= SW'(err_valid);
      end else if (err_valid && since != {SW{1'b1}}) begin
        since <= since + 1'b1;
      end
    end
  end

  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    resync_req |=> !resync_req);
  a_r2_only_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    resync_req |-> edge_q);
  a_r6_flags_agree: assert property (@(posedge clk) disable iff (!rst_n)
    resync_req |-> (primary_high && slip_low));
  a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_q |-> ($stable(primary_high) && $stable(slip_low)));
  a_r7_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    (resync_req && seen) |-> (since >= TWO_WIN));
endmodule

bind rsc_resync_ctrl rsc_resync_ctrl_chk #(.WIN_LOG2(WIN_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .resync_req(resync_req),
  .primary_high(primary_high), .slip_low(slip_low)
);

// File: tb/tb_rsc_resync_ctrl.sv
module tb_rsc_resync_ctrl;
  localparam int WIN = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_valid = 1'b0;
  logic        err_flag = 1'b0;
  logic        err_ready;
  logic [10:0] thr_primary = 11'd256;
  logic [10:0] thr_slip = 11'd32;
  logic        resync_req, primary_high, slip_low;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit       win_bits [WIN];
  logic [6:0] m_hist = '0;
  int       m_fill = 0;
  bit       m_hold = 1'b0;
  logic [6:0] gen = 7'h7F;

  rsc_resync_ctrl dut (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_flag(err_flag),
    .err_ready(err_ready), .thr_primary(thr_primary), .thr_slip(thr_slip),
    .resync_req(resync_req), .primary_high(primary_high), .slip_low(slip_low)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic bit prbs_next();
    bit n = gen[6] ^ gen[5];
    gen = {gen[5:0], n};
    return n;
  endfunction

  // mode: 0 zeros, 1 pattern, 2 random half, 3 pattern plus sparse noise,
  // 4 sparse noise only, 5 seven ones then zeros
  task automatic build(input int mode);
    for (int i = 0; i < WIN; i++) begin
      case (mode)
        0: win_bits[i] = 1'b0;
        1: win_bits[i] = prbs_next();
        2: win_bits[i] = $urandom_range(1);
        3: win_bits[i] = prbs_next() ^ ($urandom_range(99) < 2);
        4: win_bits[i] = ($urandom_range(99) < 5);
        default: win_bits[i] = (i < 7);
      endcase
    end
  endtask

  task automatic model(input bit commit, output int p, output int s,
                       output bit hi, output bit lo, output bit pulse);
    logic [6:0] h = m_hist;
    int f = m_fill;
    p = 0; s = 0;
    for (int i = 0; i < WIN; i++) begin
      if (f >= 7) s += int'((h[6] ^ h[5]) ^ win_bits[i]);
      else f++;
      h = {h[5:0], win_bits[i]};
      p += int'(win_bits[i]);
    end
    hi = (p >= int'(thr_primary));
    lo = (s < int'(thr_slip));
    pulse = hi && lo && !m_hold;
    if (commit) begin
      m_hist = h; m_fill = f; m_hold = pulse;
    end
  endtask

  task automatic drive_and_check(input string req, input bit e_hi, input bit e_lo,
                                 input bit e_pulse);
    int mid = 0;
    for (int i = 0; i < WIN; i++) begin
      if ($urandom_range(3) == 0) begin
        @(negedge clk);
        if (resync_req) mid++;
        err_valid = 1'b0;
        err_flag  = $urandom_range(1);
      end
      @(negedge clk);
      if (resync_req) mid++;
      err_valid = 1'b1;
      err_flag  = win_bits[i];
    end
    @(negedge clk);
    err_valid = 1'b0;
    err_flag  = $urandom_range(1);
    check(mid == 0, "R2 no pulse inside window", mid, 0);
    check(resync_req == e_pulse, {req, " resync_req"}, int'(resync_req), int'(e_pulse));
    check(primary_high == e_hi, {"R3 ", req, " primary_high"}, int'(primary_high), int'(e_hi));
    check(slip_low == e_lo, {"R5 ", req, " slip_low"}, int'(slip_low), int'(e_lo));
    @(negedge clk);
    check(resync_req == 1'b0, "R2 pulse lasts one cycle", int'(resync_req), 0);
  endtask

  task automatic run(input string req);
    int p, s; bit hi, lo, pu;
    model(1'b1, p, s, hi, lo, pu);
    drive_and_check(req, hi, lo, pu);
  endtask

  initial begin
    int p, s; bit hi, lo, pu;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(resync_req == 0, "R10 resync_req in reset", int'(resync_req), 0);
    check(primary_high == 0, "R10 primary_high in reset", int'(primary_high), 0);
    check(slip_low == 0, "R10 slip_low in reset", int'(slip_low), 0);
    check(err_ready == 1, "R1 err_ready", int'(err_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(resync_req == 0 && primary_high == 0 && slip_low == 0,
          "R10 outputs after reset", int'({resync_req, primary_high, slip_low}), 0);

    // R8: first seven beats are ones; threshold sits just above the count
    // that excludes them, so counting them would clear slip_low
    build(5);
    model(1'b0, p, s, hi, lo, pu);
    thr_slip = 11'(s + 1);
    run("R8 fill exclusion");
    thr_slip = 11'd32;

    build(0); run("R1 quiet window");
    build(1); run("R6 slip window pulses");
    build(1); run("R7 hold-off window");
    build(1); run("R7 pulse after hold-off");
    build(2); run("R9 random burst");
    build(2); run("R9 random burst again");

    // R3 boundary: count equals threshold, then one below threshold
    build(1);
    model(1'b0, p, s, hi, lo, pu);
    thr_primary = 11'(p);
    run("R3 count equals threshold");
    build(1);
    model(1'b0, p, s, hi, lo, pu);
    thr_primary = 11'(p + 1);
    run("R3 count below threshold");
    thr_primary = 11'd256;

    // R5 boundary: slip count equals threshold gives slip_low 0
    build(1);
    model(1'b0, p, s, hi, lo, pu);
    thr_slip = 11'(s);
    run("R5 slip count equals threshold");
    thr_slip = 11'd32;

    build(3); run("R4 pattern with sparse noise");
    build(4); run("R6 sparse noise only");
    build(1); run("R4 slip after noise");

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule